// File: doc/BRIEF.md
# Spatial Dither Bit-Depth Reducer

This block takes 12-bit-per-channel RGB pixels and lowers their effective precision to 10, 8 or 6 bits per channel. The output keeps the full 12-bit width, and the discarded low bits are forced to zero. There are two reduction methods. Plain truncation simply clears the low bits. Dithering adds pseudo-random noise to each channel before the low bits are cleared. The noise comes from one 28-bit linear feedback shift register (LFSR) per channel.

The LFSRs either share one feedback polynomial or use a different tap for each channel. Each channel has its own seed. The generators can be reloaded at every frame start, and a small frame counter is mixed into the seed so that the pattern changes from frame to frame. An optional high-pass mode subtracts the previous noise sample from the current one before it is added. This gives noise with a zero-mean difference. The sum saturates at both ends of the range.

The configuration is applied through a load strobe. The block first falls back to pass-through for one cycle, and then the new settings take effect.

Top module: `bitdepth_reducer`

## Requirements
- R1: While reset is asserted, and on the first sample after it is released, `outValid` is 0 and all three output channels are 0.
- R2: `outValid` equals `pixValid` delayed by exactly one clock, and each output channel is registered from the pixel of that same cycle.
- R3: With both dither and truncation disabled, every output channel equals its input channel one cycle later.
- R4: Truncation alone clears the low bits and adds no noise. A depth code of 0 keeps the top 6 bits (the output is the input AND 0xFC0). Code 1 keeps 8 bits (AND 0xFF0). Codes 2 and 3 keep 10 bits (AND 0xFFC).
- R5: Dither output is `sat(in + n) & ~m`, where `m` is the low-bit mask of the dither depth code (same encoding as R4). `n` is the LFSR state AND `m`, taken before the state advances. The LFSR shifts as `next = {s[26:0], s[27] ^ s[tap-1]}` on every valid pixel.
- R6: When the shared-polynomial mode is selected (`cfgRgbRandom` = 0), all channels use tap 3 (x^28+x^3+1). Otherwise R uses tap 3, G uses tap 9 and B uses tap 13.
- R7: Each channel has its own 28-bit seed. The seed is copied into that channel's LFSR in the cycle in which a new configuration takes effect.
- R8: With frame-random set, a `frameStart` reloads each LFSR with `seed ^ frameCount`. Here `frameCount` starts at 0 on each configuration and then counts up, wrapping to 0 after 15 for dither depth codes 0 and 1, or after 3 for codes 2 and 3. A pixel in the same cycle uses the state from before the reload. Without frame-random, `frameStart` has no effect.
- R9: With high-pass set, the noise term is `n - nPrev`, where `nPrev` is the previous valid pixel's noise on that channel. `nPrev` is 0 after any reload. A negative sum clamps to 0.
- R10: The dither sum saturates at 4095 and never wraps. For example, an input of 4095 at depth code 1 gives 0xFF0.
- R11: After a cycle with `cfgLoad` = 1, the next cycle runs with dither and truncation both disabled (pass-through). From the following cycle on, the new settings apply.
- R12: When dither and truncation are both enabled, dither is used and the truncation depth is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Capture the configuration inputs |
| cfgTruncEn | input | 1 | Enable plain truncation |
| cfgTruncDepth | input | 2 | Truncation depth code (0: 6 bits, 1: 8 bits, 2/3: 10 bits) |
| cfgDithEn | input | 1 | Enable dithered reduction |
| cfgDithDepth | input | 2 | Dither depth code, same encoding |
| cfgRgbRandom | input | 1 | Per-channel polynomials (1) or one shared polynomial (0) |
| cfgFrameRandom | input | 1 | Reload the LFSRs at every frame start |
| cfgHighPass | input | 1 | Subtract the previous noise sample |
| cfgSeedR | input | 28 | Seed for the R channel |
| cfgSeedG | input | 28 | Seed for the G channel |
| cfgSeedB | input | 28 | Seed for the B channel |
| frameStart | input | 1 | Frame start strobe |
| pixValid | input | 1 | Input pixel valid |
| pixR | input | 12 | Input red |
| pixG | input | 12 | Input green |
| pixB | input | 12 | Input blue |
| outValid | output | 1 | Output pixel valid |
| outR | output | 12 | Reduced red |
| outG | output | 12 | Reduced green |
| outB | output | 12 | Reduced blue |

## Verification
The hardest situation to reach from the ports is the frame counter wrapping at its limit, because it needs many frame starts under one configuration. The same is true of the high-pass path driving a sum below zero. The stimulus issues forty frame starts with a few pixels each at depth 0, and ten at depth 2, so that both wrap points are crossed. It also sweeps every depth, polynomial and high-pass combination over pixel values that include 0 and 4095, so both clamps are exercised.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  parameter int unsigned LFSR_W   = 28;
  parameter int unsigned CNT_W    = 4;
  parameter int unsigned NUM_CH   = 3;
  parameter int unsigned BASE_TAP = 3;

  typedef struct packed {
    logic       truncEn;
    logic [1:0] truncDepth;
    logic       dithEn;
    logic [1:0] dithDepth;
    logic       rgbRandom;
    logic       frameRandom;
    logic       highPass;
  } mode_t;

  typedef struct packed {
    logic             seedLoad;
    logic             advance;
    logic [CNT_W-1:0] mix;
  } strobe_t;

  // feedback tap of a channel when per-channel polynomials are selected
  function automatic int unsigned chanTap(input int unsigned ch);
    case (ch)
      0:       return 3;
      1:       return 9;
      default: return 13;
    endcase
  endfunction

  // number of kept bits for a depth code
  function automatic int keepBits(input logic [1:0] code);
    case (code)
      2'd0:    return 6;
      2'd1:    return 8;
      default: return 10;
    endcase
  endfunction

  // last value of the frame counter before it wraps
  function automatic logic [CNT_W-1:0] cntLimit(input logic [1:0] code);
    return (code < 2'd2) ? CNT_W'(15) : CNT_W'(3);
  endfunction
endpackage

// File: rtl/bdr_lfsr.sv
module bdr_lfsr #(
  parameter int unsigned W        = 28,
  parameter int unsigned BASE_TAP = 3,
  parameter int unsigned ALT_TAP  = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         useAlt,
  input  logic         load,
  input  logic         advance,
  input  logic [W-1:0] seed,
  output logic [W-1:0] state
);
  logic fb;

  assign fb = state[W-1] ^ (useAlt ? state[ALT_TAP-1] : state[BASE_TAP-1]);

  always_ff @(posedge clk) begin
    if (!rstN)        state <= '0;
    else if (load)    state <= seed;
    else if (advance) state <= {state[W-2:0], fb};
  end
endmodule

// File: rtl/bdr_chan.sv
module bdr_chan
  import bdr_pkg::*;
#(
  parameter int unsigned CH_W = 12
) (
  input  mode_t            mode,
  input  logic [CH_W-1:0]  pixIn,
  input  logic [CH_W-1:0]  stateLow,
  input  logic [CH_W-1:0]  prevNoise,
  output logic [CH_W-1:0]  noise,
  output logic [CH_W-1:0]  result
);
  localparam int unsigned SUM_W = CH_W + 2;

  function automatic logic [CH_W-1:0] lowMask(input logic [1:0] code);
    logic [CH_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(CH_W); i++)
      if (i < int'(CH_W) - keepBits(code)) m[i] = 1'b1;
    return m;
  endfunction

  logic [CH_W-1:0]         dithMask, truncMask, satVal;
  logic [SUM_W-1:0]        hpTerm;
  logic signed [SUM_W-1:0] sum;

  always_comb begin
    dithMask  = lowMask(mode.dithDepth);
    truncMask = lowMask(mode.truncDepth);
    noise     = stateLow & dithMask;
    hpTerm    = mode.highPass ? {2'b00, prevNoise} : '0;
    sum       = $signed({2'b00, pixIn}) + $signed({2'b00, noise}) - $signed(hpTerm);
    if (sum < 0)
      satVal = '0;
    else if (sum > $signed({2'b00, {CH_W{1'b1}}}))
      satVal = '1;
    else
      satVal = sum[CH_W-1:0];
    if (mode.dithEn)       result = satVal & ~dithMask;
    else if (mode.truncEn) result = pixIn & ~truncMask;
    else                   result = pixIn;
  end
endmodule

// File: rtl/bdr_ctrl.sv
module bdr_ctrl
  import bdr_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgLoad,
  input  mode_t                         cfgMode,
  input  logic [NUM_CH-1:0][LFSR_W-1:0] cfgSeed,
  input  logic                          pixValid,
  input  logic                          frameStart,
  output mode_t                         actMode,
  output logic [NUM_CH-1:0][LFSR_W-1:0] loadSeed,
  output strobe_t                       strb
);
  mode_t                         pendMode;
  logic [NUM_CH-1:0][LFSR_W-1:0] pendSeed, actSeed;
  logic                          applyQ, reseed;
  logic [CNT_W-1:0]              frameCnt;

  assign reseed = frameStart & actMode.frameRandom & ~applyQ;

  always_comb begin
    strb.seedLoad = applyQ | reseed;
    strb.mix      = applyQ ? '0 : frameCnt;
    strb.advance  = pixValid & ~strb.seedLoad;
    for (int ch = 0; ch < int'(NUM_CH); ch++)
      loadSeed[ch] = (applyQ ? pendSeed[ch] : actSeed[ch])
                     ^ {{(LFSR_W-CNT_W){1'b0}}, strb.mix};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actMode  <= '0;
      pendMode <= '0;
      actSeed  <= '0;
      pendSeed <= '0;
      applyQ   <= 1'b0;
      frameCnt <= '0;
    end else begin
      applyQ <= cfgLoad;
      if (applyQ) begin
        actMode  <= pendMode;
        actSeed  <= pendSeed;
        frameCnt <= '0;
      end else if (reseed) begin
        frameCnt <= (frameCnt >= cntLimit(actMode.dithDepth)) ? '0 : frameCnt + 1'b1;
      end
      if (cfgLoad) begin
        actMode  <= '0;
        pendMode <= cfgMode;
        pendSeed <= cfgSeed;
      end
    end
  end
endmodule

// File: rtl/bdr_datapath.sv
module bdr_datapath
  import bdr_pkg::*;
#(
  parameter int unsigned CH_W = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  mode_t                         actMode,
  input  strobe_t                       strb,
  input  logic [NUM_CH-1:0][LFSR_W-1:0] loadSeed,
  input  logic                          pixValid,
  input  logic [NUM_CH-1:0][CH_W-1:0]   pixData,
  output logic                          outValid,
  output logic [NUM_CH-1:0][CH_W-1:0]   outData
);
  logic [NUM_CH-1:0][CH_W-1:0] resData;

  for (genvar ch = 0; ch < int'(NUM_CH); ch++) begin : g_chan
    logic [LFSR_W-1:0] state;
    logic [CH_W-1:0]   noise, prevNoise;

    bdr_lfsr #(
      .W       (LFSR_W),
      .BASE_TAP(BASE_TAP),
      .ALT_TAP (chanTap(ch))
    ) uLfsr (
      .clk    (clk),
      .rstN   (rstN),
      .useAlt (actMode.rgbRandom),
      .load   (strb.seedLoad),
      .advance(strb.advance),
      .seed   (loadSeed[ch]),
      .state  (state)
    );

    bdr_chan #(.CH_W(CH_W)) uChan (
      .mode     (actMode),
      .pixIn    (pixData[ch]),
      .stateLow (state[CH_W-1:0]),
      .prevNoise(prevNoise),
      .noise    (noise),
      .result   (resData[ch])
    );

    always_ff @(posedge clk) begin
      if (!rstN)              prevNoise <= '0;
      else if (strb.seedLoad) prevNoise <= '0;
      else if (strb.advance)  prevNoise <= noise;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= pixValid;
      outData  <= resData;
    end
  end
endmodule

// File: rtl/bitdepth_reducer.sv
module bitdepth_reducer
  import bdr_pkg::*;
#(
  parameter int unsigned CH_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic              cfgTruncEn,
  input  logic [1:0]        cfgTruncDepth,
  input  logic              cfgDithEn,
  input  logic [1:0]        cfgDithDepth,
  input  logic              cfgRgbRandom,
  input  logic              cfgFrameRandom,
  input  logic              cfgHighPass,
  input  logic [LFSR_W-1:0] cfgSeedR,
  input  logic [LFSR_W-1:0] cfgSeedG,
  input  logic [LFSR_W-1:0] cfgSeedB,
  input  logic              frameStart,
  input  logic              pixValid,
  input  logic [CH_W-1:0]   pixR,
  input  logic [CH_W-1:0]   pixG,
  input  logic [CH_W-1:0]   pixB,
  output logic              outValid,
  output logic [CH_W-1:0]   outR,
  output logic [CH_W-1:0]   outG,
  output logic [CH_W-1:0]   outB
);
  mode_t                         cfgMode, actMode;
  strobe_t                       strb;
  logic [NUM_CH-1:0][LFSR_W-1:0] cfgSeed, loadSeed;
  logic [NUM_CH-1:0][CH_W-1:0]   pixData, outData;

  assign cfgMode = '{truncEn: cfgTruncEn, truncDepth: cfgTruncDepth,
                     dithEn: cfgDithEn, dithDepth: cfgDithDepth,
                     rgbRandom: cfgRgbRandom, frameRandom: cfgFrameRandom,
                     highPass: cfgHighPass};
  assign cfgSeed = {cfgSeedB, cfgSeedG, cfgSeedR};
  assign pixData = {pixB, pixG, pixR};
  assign outR    = outData[0];
  assign outG    = outData[1];
  assign outB    = outData[2];

  bdr_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgLoad   (cfgLoad),
    .cfgMode   (cfgMode),
    .cfgSeed   (cfgSeed),
    .pixValid  (pixValid),
    .frameStart(frameStart),
    .actMode   (actMode),
    .loadSeed  (loadSeed),
    .strb      (strb)
  );

  bdr_datapath #(.CH_W(CH_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .actMode (actMode),
    .strb    (strb),
    .loadSeed(loadSeed),
    .pixValid(pixValid),
    .pixData (pixData),
    .outValid(outValid),
    .outData (outData)
  );
endmodule

// File: rtl/bdr_chk.sv
module bdr_chk
  import bdr_pkg::*;
#(
  parameter int unsigned CH_W = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic            cfgLoad,
  input logic            pixValid,
  input logic [CH_W-1:0] pixR,
  input logic            outValid,
  input logic [CH_W-1:0] outR,
  input mode_t           actMode,
  input strobe_t         strb
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> outValid);
  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !outValid);
  // R3
  pass_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(actMode.dithEn) && !$past(actMode.truncEn)) |-> outR == $past(pixR));
  // R5
  low_bits_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(actMode.dithEn) && $past(actMode.dithDepth) == 2'd0)
      |-> outR[CH_W-7:0] == '0);
  // R5
  no_underrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(actMode.dithEn) && !$past(actMode.highPass))
      |-> outR[CH_W-1:CH_W-6] >= $past(pixR[CH_W-1:CH_W-6]));
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(pixR) == '1 && $past(actMode.dithEn) && !$past(actMode.highPass)
      && $past(actMode.dithDepth) == 2'd1) |-> outR[CH_W-1:CH_W-8] == '1);
  // R8
  frame_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.seedLoad |-> strb.mix <= cntLimit(actMode.dithDepth));
  // R11
  cfg_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgLoad) |-> (!actMode.dithEn && !actMode.truncEn));
endmodule

bind bitdepth_reducer bdr_chk #(.CH_W(CH_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .cfgLoad (cfgLoad),
  .pixValid(pixValid),
  .pixR    (pixR),
  .outValid(outValid),
  .outR    (outR),
  .actMode (actMode),
  .strb    (strb)
);

// File: tb/tb_bitdepth_reducer.sv
`timescale 1ns/1ps
module tb_bitdepth_reducer;
  import bdr_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0, cfgTruncEn = 1'b0, cfgDithEn = 1'b0;
  logic [1:0] cfgTruncDepth = '0, cfgDithDepth = '0;
  logic cfgRgbRandom = 1'b0, cfgFrameRandom = 1'b0, cfgHighPass = 1'b0;
  logic [27:0] cfgSeedR = '0, cfgSeedG = '0, cfgSeedB = '0;
  logic frameStart = 1'b0, pixValid = 1'b0;
  logic [11:0] pixR = '0, pixG = '0, pixB = '0;
  logic outValid;
  logic [11:0] outR, outG, outB;

  always #2.5 clk = ~clk;

  bitdepth_reducer dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgTruncEn(cfgTruncEn),
    .cfgTruncDepth(cfgTruncDepth), .cfgDithEn(cfgDithEn), .cfgDithDepth(cfgDithDepth),
    .cfgRgbRandom(cfgRgbRandom), .cfgFrameRandom(cfgFrameRandom), .cfgHighPass(cfgHighPass),
    .cfgSeedR(cfgSeedR), .cfgSeedG(cfgSeedG), .cfgSeedB(cfgSeedB),
    .frameStart(frameStart), .pixValid(pixValid), .pixR(pixR), .pixG(pixG), .pixB(pixB),
    .outValid(outValid), .outR(outR), .outG(outG), .outB(outB)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  mode_t       mAct, mPend;
  logic [27:0] mSeedA [3];
  logic [27:0] mSeedP [3];
  logic [27:0] mState [3];
  int          mPrev  [3];
  int          mFc;
  logic        mApply;
  logic        expV;
  int          expD [3];
  string       expTag;

  function automatic int maskOf(input logic [1:0] code);
    int keep;
    keep = (code == 2'd0) ? 6 : (code == 2'd1) ? 8 : 10;
    return (1 << (12 - keep)) - 1;
  endfunction

  function automatic int tapOf(input int ch, input logic rgb);
    if (!rgb) return 3;
    return (ch == 0) ? 3 : (ch == 1) ? 9 : 13;
  endfunction

  function automatic int noiseOf(input int ch);
    return int'(mState[ch][11:0]) & maskOf(mAct.dithDepth);
  endfunction

  function automatic int expectOf(input int inV, input int ch);
    int s, m;
    if (mAct.dithEn) begin
      m = maskOf(mAct.dithDepth);
      s = inV + noiseOf(ch) - (mAct.highPass ? mPrev[ch] : 0);
      if (s < 0) s = 0;
      if (s > 4095) s = 4095;
      return s & ~m & 4095;
    end
    if (mAct.truncEn) return inV & ~maskOf(mAct.truncDepth) & 4095;
    return inV;
  endfunction

  task automatic checkOne(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkOut();
    checkOne("R2", int'(outValid), int'(expV), "outValid");
    if (expV) begin
      checkOne(expTag, int'(outR), expD[0], "outR");
      checkOne(expTag, int'(outG), expD[1], "outG");
      checkOne(expTag, int'(outB), expD[2], "outB");
    end
  endtask

  task automatic step(input logic v, input int r, input int g, input int b,
                      input logic fs, input logic ld, input string tag);
    int inV [3];
    int lim;
    @(negedge clk);
    checkOut();
    pixValid = v; pixR = 12'(r); pixG = 12'(g); pixB = 12'(b);
    frameStart = fs; cfgLoad = ld;
    inV[0] = r; inV[1] = g; inV[2] = b;
    expV = v;
    expTag = tag;
    for (int ch = 0; ch < 3; ch++) expD[ch] = expectOf(inV[ch], ch);
    if (mApply) begin
      mAct = mPend;
      for (int ch = 0; ch < 3; ch++) begin
        mSeedA[ch] = mSeedP[ch]; mState[ch] = mSeedP[ch]; mPrev[ch] = 0;
      end
      mFc = 0;
      mApply = 1'b0;
    end else if (fs && mAct.frameRandom) begin
      lim = (mAct.dithDepth < 2) ? 15 : 3;
      for (int ch = 0; ch < 3; ch++) begin
        mState[ch] = mSeedA[ch] ^ 28'(mFc); mPrev[ch] = 0;
      end
      mFc = (mFc >= lim) ? 0 : mFc + 1;
    end else if (v) begin
      for (int ch = 0; ch < 3; ch++) begin
        mPrev[ch] = noiseOf(ch);
        mState[ch] = {mState[ch][26:0],
                      mState[ch][27] ^ mState[ch][tapOf(ch, mAct.rgbRandom) - 1]};
      end
    end
    if (ld) begin
      mAct = '0;
      mPend = '{truncEn: cfgTruncEn, truncDepth: cfgTruncDepth, dithEn: cfgDithEn,
                dithDepth: cfgDithDepth, rgbRandom: cfgRgbRandom,
                frameRandom: cfgFrameRandom, highPass: cfgHighPass};
      mSeedP[0] = cfgSeedR; mSeedP[1] = cfgSeedG; mSeedP[2] = cfgSeedB;
      mApply = 1'b1;
    end
  endtask

  // R11: load, then one pass-through pixel while the new settings wait
  task automatic loadCfg(input logic te, input logic [1:0] td, input logic de,
                         input logic [1:0] dd, input logic rgb, input logic fr,
                         input logic hp, input logic [27:0] sr, input logic [27:0] sg,
                         input logic [27:0] sb);
    cfgTruncEn = te; cfgTruncDepth = td; cfgDithEn = de; cfgDithDepth = dd;
    cfgRgbRandom = rgb; cfgFrameRandom = fr; cfgHighPass = hp;
    cfgSeedR = sr; cfgSeedG = sg; cfgSeedB = sb;
    step(1'b0, 0, 0, 0, 1'b0, 1'b1, "R11");
    step(1'b1, 4095, 1234, 7, 1'b0, 1'b0, "R11");
  endtask

  function automatic int patVal(input int i, input int ch, input int k);
    if (i % 7 == 0) return 4095;
    if (i % 11 == 0) return 0;
    return (i * 181 + ch * 977 + k * 53) % 4096;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int k;
    mAct = '0; mPend = '0; mFc = 0; mApply = 1'b0; expV = 1'b0; expTag = "R1";
    for (int ch = 0; ch < 3; ch++) begin
      mSeedA[ch] = '0; mSeedP[ch] = '0; mState[ch] = '0; mPrev[ch] = 0; expD[ch] = 0;
    end
    repeat (4) @(negedge clk);
    // R1 during reset
    checkOne("R1", int'(outValid), 0, "outValid in reset");
    checkOne("R1", int'(outR) + int'(outG) + int'(outB), 0, "data in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkOne("R1", int'(outValid), 0, "outValid after reset");
    checkOne("R1", int'(outR), 0, "outR after reset");

    // R3 pass-through sweep
    for (int i = 0; i < 4096; i += 41) step(1'b1, i, 4095 - i, (i * 3) % 4096, 1'b0, 1'b0, "R3");

    // R4 truncation at each depth code
    for (int d = 0; d < 4; d++) begin
      loadCfg(1'b1, 2'(d), 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 28'h1, 28'h2, 28'h3);
      for (int i = 0; i < 4096; i += 37) step(1'b1, i, 4095 - i, (i * 5) % 4096, 1'b0, 1'b0, "R4");
    end

    // R5 R6 R7 R9 R10 dither sweeps
    k = 0;
    for (int d = 0; d < 3; d++)
      for (int rgb = 0; rgb < 2; rgb++)
        for (int hp = 0; hp < 2; hp++) begin
          k++;
          loadCfg(1'b0, 2'd0, 1'b1, 2'(d), rgb[0], 1'b0, hp[0],
                  28'hACE1 + 28'(k), 28'h5A5A5A5 ^ 28'(k * 7), 28'hF00D123 + 28'(k * 13));
          for (int i = 0; i < 150; i++)
            step(1'b1, patVal(i, 0, k), patVal(i, 1, k), patVal(i, 2, k), 1'b0, 1'b0,
                 hp ? "R9" : (rgb ? "R6" : "R5"));
        end

    // R10 saturation at full scale
    loadCfg(1'b0, 2'd0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 28'hFFFFFFF, 28'hFFFF03F, 28'hABCDEF1);
    for (int i = 0; i < 30; i++) step(1'b1, 4095, 4090, 4064 + i, 1'b0, 1'b0, "R10");

    // R8 frame reseed, depth 0 wraps after 15
    loadCfg(1'b0, 2'd0, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 28'h0123457, 28'h89ABCDF, 28'h7654321);
    for (int f = 0; f < 40; f++) begin
      step(1'b0, 0, 0, 0, 1'b1, 1'b0, "R8");
      for (int i = 0; i < 3; i++) step(1'b1, 100 + i * 17, 2000, 3000 + f, 1'b0, 1'b0, "R8");
    end
    // R8 a frame start carrying a pixel
    step(1'b1, 555, 666, 777, 1'b1, 1'b0, "R8");
    // R8 depth 2 wraps after 3, with high-pass (R9)
    loadCfg(1'b0, 2'd0, 1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 28'h0FEDCBA, 28'h1111111, 28'h2222223);
    for (int f = 0; f < 10; f++) begin
      step(1'b0, 0, 0, 0, 1'b1, 1'b0, "R8");
      for (int i = 0; i < 4; i++) step(1'b1, i, 1 + f, 4095, 1'b0, 1'b0, "R8");
    end
    // R8 frame starts ignored without frame-random
    loadCfg(1'b0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 28'h3333335, 28'h4444447, 28'h5555559);
    for (int i = 0; i < 40; i++) step(1'b1, i * 50, 1000, 3500, (i % 5) == 0, 1'b0, "R8");

    // R12 dither wins over truncation
    loadCfg(1'b1, 2'd2, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 28'h6789ABC, 28'h0F0F0F1, 28'h1234567);
    for (int i = 0; i < 40; i++) step(1'b1, i * 97, 4095 - i, 2048, 1'b0, 1'b0, "R12");

    step(1'b0, 0, 0, 0, 1'b0, 1'b0, "R2");
    step(1'b0, 0, 0, 0, 1'b0, 1'b0, "R2");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule